// File: doc/BRIEF.md
# Fast-Clock Power Sequencer

This block is the fast-clock half of a two-domain power controller. The slow-clock controller asks it to bring the chip up. It then works through the boot stages in a fixed order. It releases the life-cycle reset, waits for the fuse array to finish sensing, and waits for the life-cycle logic to initialise. It then turns on second-level clock gating, samples the straps for a set number of cycles, and finally answers the slow side while it lets go of the system reset. After that it rests in an Active state.

From Active the sequencer leaves on one of two paths. The first is a software-armed low-power entry, which needs both a hint bit and the processor's wait-for-interrupt flag. The second is a peripheral reset request, which it handles locally without involving the slow side. Low-power entry is checked one cycle after the clock gates drop. If the core has already woken, the entry is called off and reported as a fall-through. If a non-volatile transaction is still running, the entry is called off and reported as an abort. Either kind of halted entry returns straight to Active.

A reset request and a low-power entry are handled one at a time, in the order they arrive. A request that arrives second is only acted on once the machine is resting again.

Top module: `fast_pwr_seq`

## Requirements
- R1: After reset the block sits in Low Power with `lc_rst_no`=0, `sys_rst_no`=0, `clk_gate_en_o`=0, `pwrup_ack_o`=0, `pwrdn_req_o`=0, `cfg_wen_o`=1, `hint_o`=0. It stays there while `pwrup_req_i` is low.
- R2: One cycle after `pwrup_req_i` is seen, `lc_rst_no` goes to 1. Clock gating stays off until `otp_done_i` has been seen and then `lc_done_i` has been seen, in that order, each for any number of wait cycles.
- R3: The cycle after `lc_done_i` is taken, `clk_gate_en_o` rises. The next cycle `strap_o` rises and stays high for exactly STRAP_CYCLES cycles.
- R4: After strap sampling, `pwrup_ack_o` and `sys_rst_no` rise in the same cycle. The acknowledge holds until `pwrup_req_i` drops, and the block then enters Active with `cfg_wen_o`=1.
- R5: In Active, entry starts only when `wfi_i` and `hint_o` are both 1. WFI alone or the hint alone has no effect. When entry starts, `clk_gate_en_o`, `cfg_wen_o` and `hint_o` all go to 0 on the next cycle.
- R6: If `wfi_i`=1 and `nvm_busy_i`=0 in the check cycle, `pwrdn_req_o` rises with `sys_rst_no`=0 and holds until `slow_ack_i`. The block then returns to Low Power and pulses `ev_lp_o` for one cycle.
- R7: If `wfi_i`=0 in the check cycle, the entry halts. `ev_fall_o` pulses while `clk_gate_en_o` is back at 1 and `pwrdn_req_o` stays 0. The next cycle is Active with `cfg_wen_o`=1.
- R8: If `wfi_i`=1 and `nvm_busy_i`=1 in the check cycle, the entry halts in the same way but pulses `ev_abort_o` instead. When both conditions hold, only the fall-through is reported.
- R9: `rst_req_i` in Active sends the block to Low Power with both resets asserted. It pulses `ev_rst_o` and clears `hint_o`. The block then reboots without `pwrup_req_i` and never raises `pwrup_ack_o` on that pass.
- R10: A reset request in the same cycle as a qualified entry wins. A reset request during entry or boot is ignored, and is taken on the first Active cycle if it is still present.
- R11: A hint write (`hint_we_i`) has no effect while `cfg_wen_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast fixed clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrup_req_i | input | 1 | Power-up request from the slow controller |
| pwrup_ack_o | output | 1 | Power-up acknowledge to the slow controller |
| pwrdn_req_o | output | 1 | Request for the slow controller to take over |
| slow_ack_i | input | 1 | Slow controller accepted the takeover |
| otp_done_i | input | 1 | Fuse sensing finished |
| lc_done_i | input | 1 | Life-cycle initialisation finished |
| nvm_busy_i | input | 1 | A flash, fuse or life-cycle transaction is in flight |
| wfi_i | input | 1 | Processor is waiting for interrupt |
| hint_we_i | input | 1 | Write strobe for the low-power hint |
| hint_wd_i | input | 1 | Write data for the low-power hint |
| rst_req_i | input | 1 | Enabled peripheral reset request |
| lc_rst_no | output | 1 | Life-cycle reset, active low |
| sys_rst_no | output | 1 | System reset, active low |
| clk_gate_en_o | output | 1 | Second-level clock gating enable |
| strap_o | output | 1 | Strap sampling strobe |
| cfg_wen_o | output | 1 | Low-power configuration write enable |
| hint_o | output | 1 | Current low-power hint |
| ev_lp_o | output | 1 | Pulse: low-power exit recorded as reset reason |
| ev_rst_o | output | 1 | Pulse: peripheral reset recorded as reset reason |
| ev_fall_o | output | 1 | Pulse: entry halted by fall-through |
| ev_abort_o | output | 1 | Pulse: entry halted by busy transaction |

## Verification
The hardest case to reach from the ports is the single check cycle, the one that follows the clock gates going off. Its outcome decides between power-down, fall-through and abort. The bench counts registers from the cycle WFI and the hint meet, then changes `wfi_i` and `nvm_busy_i` exactly inside that window, and sweeps all four combinations. The ordering between reset requests and entry is reached in the same way: the reset request is raised either in the Active cycle where entry qualifies, or one cycle later in the check cycle. The bench then stands in for the slow controller's wake-up, so that the deferred request can be seen being taken on the first Active cycle.

// File: rtl/fast_pwr_seq.sv
module fast_pwr_seq #(
  parameter int STRAP_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrup_req_i,
  output logic pwrup_ack_o,
  output logic pwrdn_req_o,
  input  logic slow_ack_i,
  input  logic otp_done_i,
  input  logic lc_done_i,
  input  logic nvm_busy_i,
  input  logic wfi_i,
  input  logic hint_we_i,
  input  logic hint_wd_i,
  input  logic rst_req_i,
  output logic lc_rst_no,
  output logic sys_rst_no,
  output logic clk_gate_en_o,
  output logic strap_o,
  output logic cfg_wen_o,
  output logic hint_o,
  output logic ev_lp_o,
  output logic ev_rst_o,
  output logic ev_fall_o,
  output logic ev_abort_o
);
  localparam int CW = $clog2(STRAP_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STRAP_CYCLES - 1);

  typedef enum logic [3:0] {
    S_LOWPWR, S_LC_REL, S_OTP, S_LCI, S_CLKEN, S_STRAP, S_ACK,
    S_ACTIVE, S_LPCHK, S_PDREQ, S_HALT
  } state_e;

  state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic self_boot_q, cfg_wen_q, hint_q;
  logic ev_lp_q, ev_rst_q, ev_fall_q, ev_abort_q;

  wire go_rst  = (state_q == S_ACTIVE) && rst_req_i;
  wire go_lp   = (state_q == S_ACTIVE) && !rst_req_i && hint_q && wfi_i;
  wire fall    = (state_q == S_LPCHK) && !wfi_i;
  wire abrt    = (state_q == S_LPCHK) && wfi_i && nvm_busy_i;
  wire pd_done = (state_q == S_PDREQ) && slow_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_LOWPWR: if (pwrup_req_i || self_boot_q) state_d = S_LC_REL;
      S_LC_REL: state_d = S_OTP;
      S_OTP:    if (otp_done_i) state_d = S_LCI;
      S_LCI:    if (lc_done_i) state_d = S_CLKEN;
      S_CLKEN:  state_d = S_STRAP;
      S_STRAP:  if (cnt_q == CNT_LAST) state_d = S_ACK;
      S_ACK:    if (self_boot_q || !pwrup_req_i) state_d = S_ACTIVE;
      S_ACTIVE: begin
        if (go_rst) state_d = S_LOWPWR;
        else if (go_lp) state_d = S_LPCHK;
      end
      S_LPCHK:  state_d = (fall || abrt) ? S_HALT : S_PDREQ;
      S_PDREQ:  if (pd_done) state_d = S_LOWPWR;
      S_HALT:   state_d = S_ACTIVE;
      default:  state_d = S_LOWPWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_LOWPWR;
      cnt_q       <= '0;
      self_boot_q <= 1'b0;
      cfg_wen_q   <= 1'b1;
      hint_q      <= 1'b0;
      ev_lp_q     <= 1'b0;
      ev_rst_q    <= 1'b0;
      ev_fall_q   <= 1'b0;
      ev_abort_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == S_STRAP && cnt_q != CNT_LAST) ? cnt_q + 1'b1 : '0;
      if (go_rst) self_boot_q <= 1'b1;
      else if (state_q == S_ACK) self_boot_q <= 1'b0;
      if (go_lp) cfg_wen_q <= 1'b0;
      else if (state_d == S_ACTIVE && state_q != S_ACTIVE) cfg_wen_q <= 1'b1;
      if (go_lp || go_rst) hint_q <= 1'b0;
      else if (hint_we_i && cfg_wen_q) hint_q <= hint_wd_i;
      ev_lp_q    <= pd_done;
      ev_rst_q   <= go_rst;
      ev_fall_q  <= fall;
      ev_abort_q <= abrt;
    end
  end

  assign lc_rst_no     = (state_q != S_LOWPWR);
  assign sys_rst_no    = (state_q == S_ACK) || (state_q == S_ACTIVE) ||
                         (state_q == S_LPCHK) || (state_q == S_HALT);
  assign clk_gate_en_o = (state_q == S_CLKEN) || (state_q == S_STRAP) || (state_q == S_ACK) ||
                         (state_q == S_ACTIVE) || (state_q == S_HALT);
  assign strap_o       = (state_q == S_STRAP);
  assign pwrup_ack_o   = (state_q == S_ACK) && !self_boot_q;
  assign pwrdn_req_o   = (state_q == S_PDREQ);
  assign cfg_wen_o     = cfg_wen_q;
  assign hint_o        = hint_q;
  assign ev_lp_o       = ev_lp_q;
  assign ev_rst_o      = ev_rst_q;
  assign ev_fall_o     = ev_fall_q;
  assign ev_abort_o    = ev_abort_q;
endmodule

// File: rtl/fast_pwr_seq_chk.sv
module fast_pwr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwrup_req_i,
  input logic pwrup_ack_o,
  input logic pwrdn_req_o,
  input logic slow_ack_i,
  input logic lc_rst_no,
  input logic sys_rst_no,
  input logic clk_gate_en_o,
  input logic strap_o,
  input logic cfg_wen_o,
  input logic hint_o,
  input logic ev_lp_o,
  input logic ev_rst_o,
  input logic ev_fall_o,
  input logic ev_abort_o
);
  p_lc_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lc_rst_no |-> !sys_rst_no && !clk_gate_en_o);
  p_strap_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_o |-> clk_gate_en_o && !sys_rst_no);
  p_ack_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrup_ack_o && pwrup_req_i |=> pwrup_ack_o);
  p_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_wen_o) |-> !hint_o && !clk_gate_en_o);
  p_pd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_req_o && !slow_ack_i |=> pwrdn_req_o);
  p_pd_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_req_o |-> !sys_rst_no && !clk_gate_en_o);
  p_lp_ev_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_lp_o |-> !lc_rst_no && !pwrdn_req_o);
  p_halt_back_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_fall_o || ev_abort_o) |-> clk_gate_en_o && !pwrdn_req_o);
  p_halt_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_fall_o || ev_abort_o) |=> cfg_wen_o);
  p_one_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev_fall_o && ev_abort_o));
  p_rst_ev_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rst_o |-> !lc_rst_no && !sys_rst_no && !hint_o);
  p_hint_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wen_o |=> !hint_o);
endmodule

bind fast_pwr_seq fast_pwr_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwrup_req_i(pwrup_req_i), .pwrup_ack_o(pwrup_ack_o),
  .pwrdn_req_o(pwrdn_req_o), .slow_ack_i(slow_ack_i), .lc_rst_no(lc_rst_no),
  .sys_rst_no(sys_rst_no), .clk_gate_en_o(clk_gate_en_o), .strap_o(strap_o),
  .cfg_wen_o(cfg_wen_o), .hint_o(hint_o), .ev_lp_o(ev_lp_o), .ev_rst_o(ev_rst_o),
  .ev_fall_o(ev_fall_o), .ev_abort_o(ev_abort_o)
);

// File: tb/fast_pwr_seq_test.sv
module fast_pwr_seq_test;
  localparam int STRAP = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwrup_req = 0, slow_ack = 0, otp_done = 0, lc_done = 0, busy = 0;
  logic wfi = 0, hint_we = 0, hint_wd = 0, rst_req = 0;
  logic pwrup_ack, pwrdn_req, lc_rst_n, sys_rst_n, cg_en, strap, cfg_wen, hint;
  logic ev_lp, ev_rst, ev_fall, ev_abort;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fast_pwr_seq #(.STRAP_CYCLES(STRAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwrup_req_i(pwrup_req), .pwrup_ack_o(pwrup_ack),
    .pwrdn_req_o(pwrdn_req), .slow_ack_i(slow_ack), .otp_done_i(otp_done),
    .lc_done_i(lc_done), .nvm_busy_i(busy), .wfi_i(wfi), .hint_we_i(hint_we),
    .hint_wd_i(hint_wd), .rst_req_i(rst_req), .lc_rst_no(lc_rst_n), .sys_rst_no(sys_rst_n),
    .clk_gate_en_o(cg_en), .strap_o(strap), .cfg_wen_o(cfg_wen), .hint_o(hint),
    .ev_lp_o(ev_lp), .ev_rst_o(ev_rst), .ev_fall_o(ev_fall), .ev_abort_o(ev_abort));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  task automatic set_hint(logic v);
    hint_we = 1; hint_wd = v; step(); hint_we = 0;
  endtask

  task automatic boot(int d_otp, int d_lc, bit self);
    if (!self) pwrup_req = 1;
    step();
    check("R2 lc release", {lc_rst_n, sys_rst_n, cg_en}, 3'b100);
    step();
    for (int i = 0; i < d_otp; i++) begin
      step(); check("R2 otp wait", {lc_rst_n, cg_en}, 2'b10);
    end
    otp_done = 1; step();
    for (int i = 0; i < d_lc; i++) begin
      step(); check("R2 lc wait", cg_en, 0);
    end
    lc_done = 1; step();
    check("R3 gate on", {cg_en, strap, sys_rst_n}, 3'b100);
    step();
    for (int i = 0; i < STRAP; i++) begin
      check("R3 strap", strap, 1); step();
    end
    check("R4 ack", {strap, sys_rst_n, pwrup_ack}, {2'b01, !self});
    if (!self) begin
      step(); step();
      check("R4 ack hold", pwrup_ack, 1);
      pwrup_req = 0;
    end
    step();
    check("R4 active", {pwrup_ack, cfg_wen, sys_rst_n, cg_en}, 4'b0111);
    otp_done = 0; lc_done = 0;
  endtask

  task automatic arm_entry();
    set_hint(1);
    check("R5 hint set", hint, 1);
    wfi = 1; step();
    check("R5 entry", {cg_en, cfg_wen, hint}, 3'b000);
  endtask

  initial begin
    step(); step(); rst_n = 1;
    check("R1 reset", {lc_rst_n, sys_rst_n, cg_en, pwrup_ack, pwrdn_req, cfg_wen, hint}, 7'b0000010);
    repeat (5) step();
    check("R1 idle", {lc_rst_n, cg_en}, 2'b00);
    rst_req = 1; repeat (3) step();
    check("R10 rst ignored in low power", {lc_rst_n, ev_rst}, 2'b00);
    rst_req = 0;

    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++) begin
        do_reset(); boot(a, b, 0);
      end

    wfi = 1; repeat (3) step();
    check("R5 wfi only", {cg_en, cfg_wen, pwrdn_req}, 3'b110);
    wfi = 0; set_hint(1); repeat (3) step();
    check("R5 hint only", {cg_en, hint, pwrdn_req}, 3'b110);
    set_hint(0);

    for (int c = 0; c < 4; c++) begin
      bit w = c[0];
      bit nb = c[1];
      arm_entry();
      wfi = w; busy = nb; step();
      if (w && !nb) begin
        check("R6 pd req", {pwrdn_req, sys_rst_n, ev_fall, ev_abort}, 4'b1000);
        step(); step();
        check("R6 pd hold", pwrdn_req, 1);
        slow_ack = 1; step(); slow_ack = 0; wfi = 0;
        check("R6 low power", {pwrdn_req, lc_rst_n, ev_lp}, 3'b001);
        set_hint(1);
        check("R11 hint locked", {hint, ev_lp}, 2'b00);
        hint_we = 0;
        boot(1, 1, 0);
      end else begin
        check("R7 R8 halt", {ev_fall, ev_abort, cg_en, pwrdn_req, cfg_wen},
              {!w, w && nb, 3'b100});
        step();
        check("R7 back active", {cfg_wen, ev_fall, ev_abort, cg_en}, 4'b1001);
      end
      wfi = 0; busy = 0;
    end

    set_hint(1);
    rst_req = 1; step();
    check("R9 reset", {lc_rst_n, sys_rst_n, ev_rst, hint, cg_en}, 5'b00100);
    rst_req = 0;
    boot(0, 1, 1);

    set_hint(1);
    wfi = 1; rst_req = 1; step();
    check("R10 reset wins", {ev_rst, pwrdn_req, hint, cfg_wen, lc_rst_n}, 5'b10010);
    rst_req = 0;
    boot(1, 0, 1);
    repeat (3) step();
    check("R10 entry wiped", {cg_en, cfg_wen, pwrdn_req}, 3'b110);
    wfi = 0;

    arm_entry();
    rst_req = 1; step();
    check("R10 rst deferred", {pwrdn_req, ev_rst}, 2'b10);
    slow_ack = 1; step(); slow_ack = 0; wfi = 0;
    check("R10 lp first", {ev_lp, ev_rst}, 2'b10);
    boot(0, 0, 0);
    step();
    check("R10 rst taken", {ev_rst, lc_rst_n}, 2'b10);
    rst_req = 0;
    boot(0, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule